// File: doc/BRIEF.md
# Mixed-Sign Multiply-Accumulate Unit with Guard Bits

This block multiplies two 16-bit operands and adds the product into one of sixteen 40-bit accumulators. Each operand has its own sign control, so one operation can be signed by signed, unsigned by unsigned, or mixed. A mode input selects fractional or integer alignment of the product. The accumulators hold 8 guard bits above a 32-bit body, so sums can grow past the 32-bit range without wrapping.

Each strobed operation reads the selected accumulator, adds the extended product to it, and writes the sum back. A clear select instead writes the extended product alone. On the next clock edge the new value is shown on a registered output, along with a flag. The flag reports whether the guard bits carry information beyond the sign of the 32-bit body. Rounding, saturation and data movement belong to the surrounding datapath.

Top module: `mac40_unit`

## Requirements
- R1: Each operand is read as 16-bit two's complement when its sign input is 1, and as an unsigned value in 0..65535 when its sign input is 0. The two operands are controlled independently.
- R2: In integer mode (`frac_mode`=0) the product is right-justified in bits 31:0. If either operand is signed, the product is sign-extended to 40 bits; if both are unsigned, it is zero-extended.
- R3: When `frac_mode`=1 and both operands are signed, the extended product is shifted left by one bit, so 0x8000 times 0x8000 gives 0x00_8000_0000. When `frac_mode`=1 and either operand is unsigned, the integer alignment of R2 is used.
- R4: With `clear_sel`=0, the accumulator selected by `acc_sel` (0..15) becomes its old value plus the extended product, modulo 2^40. The other fifteen accumulators keep their values.
- R5: With `clear_sel`=1, the selected accumulator is loaded with the extended product and its old value is discarded.
- R6: The value written by an operation appears on `result` one clock edge after the edge that samples `in_valid`=1. `out_valid` is high for that cycle. The layout is extension in 39:32, high portion in 31:16 and low portion in 15:0.
- R7: Operations issued on consecutive cycles to the same accumulator each add to the value written by the one before.
- R8: `ext_used` is 1 exactly when bits 39:31 of `result` are not all equal.
- R9: While `in_valid`=0, no accumulator changes and `result` and `ext_used` hold their values, whatever the other inputs do.
- R10: While `rst` is high, and on the first cycle after it falls, `out_valid`, `result` and `ext_used` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| a_signed | input | 1 | 1: op_a is two's complement |
| b_signed | input | 1 | 1: op_b is two's complement |
| frac_mode | input | 1 | 1: fractional alignment |
| acc_sel | input | 4 | Accumulator index |
| clear_sel | input | 1 | 1: load product, 0: add product |
| result | output | 40 | Value just written to the selected accumulator |
| ext_used | output | 1 | Guard bits differ from bit 31 |
| out_valid | output | 1 | result holds a fresh value |

## Verification
Every result is due exactly one clock edge after the edge that samples the strobe. Inputs are driven on the falling edge, and each output is checked on the following falling edge, which sits half a period after the rising edge that loaded the output registers. Back-to-back tests drive the next operation at that same falling edge, so the accumulator read-after-write path is checked with no idle cycle in between. Idle windows are checked at each falling edge for unchanged outputs. After an idle window, a zero-product accumulate reads the accumulator back through the normal result path.

// File: rtl/mac40_pkg.sv
package mac40_pkg;
  localparam int OP_W    = 16;
  localparam int GUARD_W = 8;
  localparam int ACC_W   = 2 * OP_W + GUARD_W;
  localparam int NUM_ACC = 16;

  typedef struct packed {
    logic a_signed;
    logic b_signed;
    logic frac;
  } mul_mode_t;
endpackage

// File: rtl/mac40_mult.sv
module mac40_mult
  import mac40_pkg::*;
#(
  parameter int OPW  = OP_W,
  parameter int ACCW = ACC_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OPW-1:0]  op_a,
  input  logic [OPW-1:0]  op_b,
  input  mul_mode_t       mode,
  output logic [ACCW-1:0] prod_ext
);
  localparam int XW = OPW + 1;
  localparam int PW = 2 * XW;

  logic signed [XW-1:0] a_x, b_x;
  logic signed [PW-1:0] full;
  logic [ACCW-1:0]      aligned;
  logic                 shift_en;

  always_comb begin
    a_x      = $signed({mode.a_signed & op_a[OPW-1], op_a});
    b_x      = $signed({mode.b_signed & op_b[OPW-1], op_b});
    full     = a_x * b_x;
    aligned  = {{(ACCW-PW){full[PW-1]}}, full};
    shift_en = mode.frac & mode.a_signed & mode.b_signed;
  end

  generate
    if (ACCW > PW) begin : g_shift
      assign prod_ext = shift_en ? {aligned[ACCW-2:0], 1'b0} : aligned;
    end else begin : g_noshift
      assign prod_ext = aligned;
    end
  endgenerate

  // R2
  unsigned_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode.a_signed && !mode.b_signed) |-> (prod_ext[ACCW-1:2*OPW] == '0));

  // R3
  frac_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    (mode.frac && mode.a_signed && mode.b_signed) |-> (prod_ext[0] == 1'b0));
endmodule

// File: rtl/mac40_regfile.sv
module mac40_regfile
  import mac40_pkg::*;
#(
  parameter int W = ACC_W,
  parameter int N = NUM_ACC,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/mac40_accum.sv
module mac40_accum
  import mac40_pkg::*;
#(
  parameter int W   = ACC_W,
  parameter int OPW = OP_W
) (
  input  logic         clear,
  input  logic [W-1:0] acc_old,
  input  logic [W-1:0] prod,
  output logic [W-1:0] acc_new,
  output logic         guard_live
);
  logic [W-1:0]           base;
  logic [W-2*OPW:0]       top_bits;

  always_comb begin
    base       = clear ? '0 : acc_old;
    acc_new    = base + prod;
    top_bits   = acc_new[W-1:2*OPW-1];
    guard_live = !((top_bits == '0) || (top_bits == '1));
  end
endmodule

// File: rtl/mac40_unit.sv
module mac40_unit
  import mac40_pkg::*;
#(
  parameter int OPW  = OP_W,
  parameter int GW   = GUARD_W,
  parameter int NACC = NUM_ACC,
  localparam int ACCW = 2 * OPW + GW,
  localparam int SELW = $clog2(NACC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [OPW-1:0]  op_a,
  input  logic [OPW-1:0]  op_b,
  input  logic            a_signed,
  input  logic            b_signed,
  input  logic            frac_mode,
  input  logic [SELW-1:0] acc_sel,
  input  logic            clear_sel,
  output logic [ACCW-1:0] result,
  output logic            ext_used,
  output logic            out_valid
);
  mul_mode_t       mode;
  logic [ACCW-1:0] prod_ext, acc_old, acc_new;
  logic            guard_live;

  assign mode = '{a_signed: a_signed, b_signed: b_signed, frac: frac_mode};

  mac40_mult #(.OPW(OPW), .ACCW(ACCW)) u_mult (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
    .mode(mode), .prod_ext(prod_ext)
  );

  mac40_regfile #(.W(ACCW), .N(NACC)) u_rf (
    .clk(clk), .we(in_valid), .addr(acc_sel),
    .wdata(acc_new), .rdata(acc_old)
  );

  mac40_accum #(.W(ACCW), .OPW(OPW)) u_acc (
    .clear(clear_sel), .acc_old(acc_old), .prod(prod_ext),
    .acc_new(acc_new), .guard_live(guard_live)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      ext_used  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= acc_new;
        ext_used <= guard_live;
      end
    end
  end

  // R6
  out_valid_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(ext_used) && !out_valid));

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && clear_sel && op_a == '0) |=> (result == '0 && !ext_used));
endmodule

// File: tb/mac40_unit_tb.sv
module mac40_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] op_a, op_b;
  logic        a_signed, b_signed, frac_mode, clear_sel;
  logic [3:0]  acc_sel;
  logic [39:0] result;
  logic        ext_used, out_valid;

  int errors = 0;
  int checks = 0;
  logic [39:0] model [16];

  always #2 clk = ~clk;

  mac40_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .a_signed(a_signed), .b_signed(b_signed), .frac_mode(frac_mode),
    .acc_sel(acc_sel), .clear_sel(clear_sel), .result(result),
    .ext_used(ext_used), .out_valid(out_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [39:0] prod_of(input logic [15:0] a, input logic [15:0] b,
                                          input bit as, input bit bs, input bit fr);
    logic signed [63:0] av, bv, p;
    av = as ? {{48{a[15]}}, a} : {48'b0, a};
    bv = bs ? {{48{b[15]}}, b} : {48'b0, b};
    p  = av * bv;
    if (fr && as && bs) p = p <<< 1;
    return p[39:0];
  endfunction

  function automatic bit ext_of(input logic [39:0] v);
    return !(v[39:31] == 9'h000 || v[39:31] == 9'h1FF);
  endfunction

  // Called at a falling edge: drives one operation, checks it on the next falling edge.
  task automatic op(input logic [15:0] a, input logic [15:0] b, input bit as, input bit bs,
                    input bit fr, input int sel, input bit clr, input string tag);
    logic [39:0] exp;
    op_a = a; op_b = b; a_signed = as; b_signed = bs; frac_mode = fr;
    acc_sel = 4'(sel); clear_sel = clr; in_valid = 1'b1;
    exp = (clr ? 40'd0 : model[sel]) + prod_of(a, b, as, bs, fr);
    model[sel] = exp;
    @(negedge clk);
    chk(out_valid === 1'b1, {tag, " R6 valid"}, {39'b0, out_valid}, 40'd1);
    chk(result === exp, tag, result, exp);
    chk(ext_used === ext_of(exp), {tag, " R8 flag"}, {39'b0, ext_used}, {39'b0, ext_of(exp)});
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] corners [8];
    logic [39:0] held;
    corners = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'hC001, 16'h8001};
    rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0; a_signed = 1'b0;
    b_signed = 1'b0; frac_mode = 1'b0; acc_sel = '0; clear_sel = 1'b0;
    repeat (3) @(negedge clk);
    chk(result === 40'd0 && out_valid === 1'b0 && ext_used === 1'b0, "R10 reset", result, 40'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(result === 40'd0 && out_valid === 1'b0, "R10 after reset", result, 40'd0);

    for (int i = 0; i < 16; i++) op(16'h0, 16'h0, 1'b0, 1'b0, 1'b0, i, 1'b1, "R5 init clear");

    // Fractional -1 x -1 and mixed/unsigned alignment
    op(16'h8000, 16'h8000, 1'b1, 1'b1, 1'b1, 0, 1'b1, "R3 frac -1x-1");
    chk(result === 40'h00_8000_0000, "R3 literal", result, 40'h00_8000_0000);
    op(16'h8000, 16'h8000, 1'b1, 1'b0, 1'b1, 1, 1'b1, "R3 frac mixed no shift");
    op(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 2, 1'b1, "R2 unsigned max");
    chk(result === 40'h00_FFFE_0001, "R2 literal", result, 40'h00_FFFE_0001);
    op(16'hFFFF, 16'h0002, 1'b1, 1'b0, 1'b0, 3, 1'b1, "R1 signed x unsigned");
    chk(result === 40'hFF_FFFF_FFFE, "R1 literal", result, 40'hFF_FFFF_FFFE);

    // Sweep over corner operands, sign pairs and modes, accumulating
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int m = 0; m < 8; m++)
          op(corners[i], corners[j], m[0], m[1], m[2], (i * 8 + j + m) % 16, 1'b0, "R4 sweep");

    // Back-to-back into one register: growth into guard bits
    for (int k = 0; k < 6; k++) op(16'h7FFF, 16'h7FFF, 1'b1, 1'b1, 1'b1, 5, 1'b0, "R7 back-to-back");
    chk(ext_used === 1'b1, "R8 guard in use", {39'b0, ext_used}, 40'd1);

    // Wraparound modulo 2^40
    for (int k = 0; k < 300; k++) op(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 6, 1'b0, "R4 wrap");

    // Idle with junk inputs
    held = result;
    op_a = 16'hDEAD; op_b = 16'hBEEF; acc_sel = 4'd6; clear_sel = 1'b1; a_signed = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(result === held && out_valid === 1'b0, "R9 idle hold", result, held);
    end
    op(16'h0, 16'h1234, 1'b0, 1'b0, 1'b0, 6, 1'b0, "R9 register untouched");

    // Random mix
    for (int k = 0; k < 2000; k++)
      op(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
         int'($urandom % 16), ($urandom % 8) == 0, "R4 random");

    // All registers independent
    for (int i = 0; i < 16; i++) op(16'h0, 16'h0, 1'b0, 1'b0, 1'b0, i, 1'b0, "R4 readback");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule